// File: doc/BRIEF.md
# ECC Error Capture and Reporting Unit

This unit watches the per-access error indications from the ECC checkers of two memories, a flash array and a RAM array. Each memory reports a valid pulse, a flag telling a non-correctable error from a corrected single-bit error, and the details of the failing access. A configuration word selects which of the four error kinds are reported. A reported error sets a sticky status flag, raises the interrupt, and stores the failing access in that memory's own capture set. The interrupt also covers errors that the requesting master never observes, such as a discarded speculative fetch or a buffered write.

Software reaches configuration, status and the captured data through a word-indexed register port. Writes take effect at the clock edge and reads are combinational. A non-correctable error always ends its access with a bus error, whatever the configuration. When the parameter `ECC_PRESENT` is 0, no capture logic is built and every register word reads as a reserved zero location.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset every register word reads 0 and `irq` is low.
- R2: Word 0 is the 8-bit configuration word. Bit 0 enables RAM non-correctable reporting, bit 1 flash non-correctable, bit 2 RAM single-bit, and bit 3 flash single-bit. Bits 7:4 and 31:8 always read 0.
- R3: Word 1 is the status word, with flags at the same bit positions as the enables in word 0. A flag is set at the clock edge that ends a cycle carrying an enabled error of its kind. It stays set until a write of 1 to that bit. Writing 0 leaves it unchanged. If a new error of a kind arrives in the same cycle as a clear of that kind, the flag stays set.
- R4: `irq` is high exactly when at least one status flag is set.
- R5: An error whose kind is disabled in word 0 sets no flag, loads no capture register and does not raise `irq`.
- R6: Flash capture: word 2 holds the address, word 3 the master number, word 4 the attributes and word 5 the data. All four are taken from the flash inputs of the cycle that carried a reported flash error. They load only if that error kind's flag was clear in that cycle.
- R7: RAM capture: word 6 holds the address, word 7 the ECC syndrome, word 8 the master number, word 9 the attributes and word 10 the data. They load under the same rule as R6, applied to RAM errors.
- R8: While an error kind's flag is set, later errors of that kind leave the capture words unchanged, so the first error is kept.
- R9: A flash error and a RAM error in the same cycle are both captured and both flags are set.
- R10: `flash_bus_err` / `ram_bus_err` are high in the same cycle as a non-correctable error of that memory, whatever the configuration. They are low for single-bit errors.
- R11: Words 11 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| flash_err_vld | input | 1 | Flash ECC error in this cycle |
| flash_err_multi | input | 1 | 1: non-correctable, 0: single-bit |
| flash_addr | input | 32 | Failing flash address |
| flash_master | input | 4 | Master number of the flash access |
| flash_attr | input | 4 | Flash access attributes |
| flash_data | input | 32 | Flash data of the failing access |
| flash_bus_err | output | 1 | Bus error for the current flash access |
| ram_err_vld | input | 1 | RAM ECC error in this cycle |
| ram_err_multi | input | 1 | 1: non-correctable, 0: single-bit |
| ram_addr | input | 32 | Failing RAM address |
| ram_master | input | 4 | Master number of the RAM access |
| ram_attr | input | 4 | RAM access attributes |
| ram_data | input | 32 | RAM data of the failing access |
| ram_syndrome | input | 7 | ECC syndrome of the RAM access |
| ram_bus_err | output | 1 | Bus error for the current RAM access |
| irq | output | 1 | ECC error interrupt |

## Verification
The bench aims at a second error of the same kind arriving while the first is still flagged. A unit that ignored the flag would overwrite the capture and lose the first failure. It also drives a status clear in the same cycle as a new error of that kind. Letting the clear win would drop an interrupt. Errors of disabled kinds must stay silent in flags and captures yet still end the access with a bus error. Simultaneous flash and RAM errors catch a design that shares a single load path between the two capture sets.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int NT = 4;
  localparam int T_RNC = 0;
  localparam int T_FNC = 1;
  localparam int T_RSB = 2;
  localparam int T_FSB = 3;

  localparam logic [NT-1:0] FLASH_KINDS = 4'b1010;
  localparam logic [NT-1:0] RAM_KINDS   = 4'b0101;
  localparam logic [7:0]    CFG_MASK    = 8'h0F;

  localparam logic [3:0] A_CFG   = 4'd0;
  localparam logic [3:0] A_STAT  = 4'd1;
  localparam logic [3:0] A_FADDR = 4'd2;
  localparam logic [3:0] A_FMST  = 4'd3;
  localparam logic [3:0] A_FATTR = 4'd4;
  localparam logic [3:0] A_FDATA = 4'd5;
  localparam logic [3:0] A_RADDR = 4'd6;
  localparam logic [3:0] A_RSYND = 4'd7;
  localparam logic [3:0] A_RMST  = 4'd8;
  localparam logic [3:0] A_RATTR = 4'd9;
  localparam logic [3:0] A_RDATA = 4'd10;

  // Sort the raw error indications into the four kinds, by status bit.
  function automatic logic [NT-1:0] classify(logic f_vld, logic f_nc,
                                             logic r_vld, logic r_nc);
    logic [NT-1:0] k;
    k        = '0;
    k[T_RNC] = r_vld & r_nc;
    k[T_FNC] = f_vld & f_nc;
    k[T_RSB] = r_vld & ~r_nc;
    k[T_FSB] = f_vld & ~f_nc;
    return k;
  endfunction

  // A capture set loads when one of its kinds is reported with its flag clear.
  function automatic logic take_capture(logic [NT-1:0] ev, logic [NT-1:0] flags,
                                        logic [NT-1:0] sel);
    return |(ev & ~flags & sel);
  endfunction
endpackage

// File: rtl/ecc_hold_reg.sv
module ecc_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_r <= '0;
    else if (load_i) q_r <= d_i;
  end

  assign q_o = q_r;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(q_o)); // R8
endmodule

// File: rtl/ecc_status_unit.sv
module ecc_status_unit #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] flags_q;

  // A new event outranks a clear of the same bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;
  assign irq_o   = |flags_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & ~clr_i) != '0) |=>
      ((flags_q & $past(flags_q & ~clr_i)) == $past(flags_q & ~clr_i))); // R3

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|set_i)); // R4
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
#(
  parameter int AW = 32,
  parameter int MW = 4,
  parameter int TW = 4,
  parameter int DW = 32,
  parameter int SW = 7,
  parameter bit ECC_PRESENT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          flash_err_vld,
  input  logic          flash_err_multi,
  input  logic [AW-1:0] flash_addr,
  input  logic [MW-1:0] flash_master,
  input  logic [TW-1:0] flash_attr,
  input  logic [DW-1:0] flash_data,
  output logic          flash_bus_err,
  input  logic          ram_err_vld,
  input  logic          ram_err_multi,
  input  logic [AW-1:0] ram_addr,
  input  logic [MW-1:0] ram_master,
  input  logic [TW-1:0] ram_attr,
  input  logic [DW-1:0] ram_data,
  input  logic [SW-1:0] ram_syndrome,
  output logic          ram_bus_err,
  output logic          irq
);
  localparam int FW = AW + MW + TW + DW;
  localparam int RW = FW + SW;

  generate
    if (ECC_PRESENT) begin : g_ecc
      logic [7:0]    cfg_q;
      logic [NT-1:0] ev;
      logic [NT-1:0] clr;
      logic [NT-1:0] flags;
      logic          f_load;
      logic          r_load;
      logic [FW-1:0] f_cap;
      logic [RW-1:0] r_cap;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             cfg_q <= '0;
        else if (reg_we && reg_addr == A_CFG)   cfg_q <= reg_wdata & CFG_MASK;
      end

      assign ev     = classify(flash_err_vld, flash_err_multi, ram_err_vld, ram_err_multi)
                      & cfg_q[NT-1:0];
      assign clr    = (reg_we && reg_addr == A_STAT) ? reg_wdata[NT-1:0] : '0;
      assign f_load = take_capture(ev, flags, FLASH_KINDS);
      assign r_load = take_capture(ev, flags, RAM_KINDS);

      ecc_status_unit #(.N(NT)) u_status (
        .clk(clk), .rst_n(rst_n), .set_i(ev), .clr_i(clr),
        .flags_o(flags), .irq_o(irq)
      );

      ecc_hold_reg #(.W(FW)) u_flash_cap (
        .clk(clk), .rst_n(rst_n), .load_i(f_load),
        .d_i({flash_addr, flash_master, flash_attr, flash_data}), .q_o(f_cap)
      );

      ecc_hold_reg #(.W(RW)) u_ram_cap (
        .clk(clk), .rst_n(rst_n), .load_i(r_load),
        .d_i({ram_addr, ram_syndrome, ram_master, ram_attr, ram_data}), .q_o(r_cap)
      );

      assign flash_bus_err = flash_err_vld & flash_err_multi;
      assign ram_bus_err   = ram_err_vld & ram_err_multi;

      always_comb begin
        reg_rdata = '0;
        case (reg_addr)
          A_CFG:   reg_rdata = 32'(cfg_q);
          A_STAT:  reg_rdata = 32'(flags);
          A_FADDR: reg_rdata = 32'(f_cap[FW-1 -: AW]);
          A_FMST:  reg_rdata = 32'(f_cap[DW+TW+MW-1 -: MW]);
          A_FATTR: reg_rdata = 32'(f_cap[DW+TW-1 -: TW]);
          A_FDATA: reg_rdata = 32'(f_cap[DW-1:0]);
          A_RADDR: reg_rdata = 32'(r_cap[RW-1 -: AW]);
          A_RSYND: reg_rdata = 32'(r_cap[FW-AW+SW-1 -: SW]);
          A_RMST:  reg_rdata = 32'(r_cap[DW+TW+MW-1 -: MW]);
          A_RATTR: reg_rdata = 32'(r_cap[DW+TW-1 -: TW]);
          A_RDATA: reg_rdata = 32'(r_cap[DW-1:0]);
          default: reg_rdata = '0;
        endcase
      end

      for (genvar k = 0; k < NT; k++) begin : g_off
        AST_OFF_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
          (!cfg_q[k] && !flags[k]) |=> !flags[k]); // R5
      end

      AST_BOTH_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[T_FNC] && !flags[T_FNC] && ev[T_RNC] && !flags[T_RNC]) |=>
          (f_cap[DW-1:0] == $past(flash_data) && r_cap[DW-1:0] == $past(ram_data))); // R9
    end else begin : g_none
      assign reg_rdata     = '0;
      assign flash_bus_err = 1'b0;
      assign ram_bus_err   = 1'b0;
      assign irq           = 1'b0;
    end
  endgenerate
endmodule

// File: tb/ecc_err_logger_tb.sv
`timescale 1ns/100ps
module ecc_err_logger_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        f_vld = 0, f_multi = 0, r_vld = 0, r_multi = 0;
  logic [31:0] f_addr = 0, f_data = 0, r_addr = 0, r_data = 0;
  logic [3:0]  f_mst = 0, f_attr = 0, r_mst = 0, r_attr = 0;
  logic [6:0]  r_synd = 0;
  logic        flash_bus_err, ram_bus_err, irq;

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [7:0]  m_cfg;
  logic [3:0]  m_stat;
  logic [31:0] m_fa, m_fd, m_ra, m_rd;
  logic [3:0]  m_fm, m_ft, m_rm, m_rt;
  logic [6:0]  m_rs;

  always #2 clk = ~clk;

  ecc_err_logger dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flash_err_vld(f_vld), .flash_err_multi(f_multi), .flash_addr(f_addr),
    .flash_master(f_mst), .flash_attr(f_attr), .flash_data(f_data),
    .flash_bus_err(flash_bus_err),
    .ram_err_vld(r_vld), .ram_err_multi(r_multi), .ram_addr(r_addr),
    .ram_master(r_mst), .ram_attr(r_attr), .ram_data(r_data),
    .ram_syndrome(r_synd), .ram_bus_err(ram_bus_err), .irq(irq)
  );

  task automatic finish_up();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end

  task automatic chk(logic [31:0] got, logic [31:0] exp, string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(int idx);
    case (idx)
      0: return {24'b0, m_cfg};
      1: return {28'b0, m_stat};
      2: return m_fa;
      3: return {28'b0, m_fm};
      4: return {28'b0, m_ft};
      5: return m_fd;
      6: return m_ra;
      7: return {25'b0, m_rs};
      8: return {28'b0, m_rm};
      9: return {28'b0, m_rt};
      10: return m_rd;
      default: return 32'b0;
    endcase
  endfunction

  function automatic string word_tag(int idx);
    if (idx == 0) return "R2 cfg";
    if (idx == 1) return "R3 status";
    if (idx <= 5) return "R6 flash capture";
    if (idx <= 10) return "R7 ram capture";
    return "R11 unmapped";
  endfunction

  task automatic rd(int idx, string tag);
    reg_addr = 4'(idx);
    #0.2;
    chk(reg_rdata, exp_word(idx), $sformatf("%s %s word %0d", tag, word_tag(idx), idx));
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < 16; i++) rd(i, tag);
    chk({31'b0, irq}, {31'b0, (m_stat != 0)}, {tag, " R4 irq"});
  endtask

  // One clock: bus error check before the edge, model update at the edge, idle after.
  task automatic tick();
    logic [3:0] kinds, clr, nstat;
    bit fload, rload;
    #0.2;
    chk({31'b0, flash_bus_err}, {31'b0, f_vld & f_multi}, "R10 flash bus error");
    chk({31'b0, ram_bus_err},   {31'b0, r_vld & r_multi}, "R10 ram bus error");
    kinds = {f_vld && !f_multi && m_cfg[3], r_vld && !r_multi && m_cfg[2],
             f_vld && f_multi && m_cfg[1],  r_vld && r_multi && m_cfg[0]};
    clr   = (reg_we && reg_addr == 4'd1) ? reg_wdata[3:0] : 4'b0;
    fload = (kinds[1] && !m_stat[1]) || (kinds[3] && !m_stat[3]);
    rload = (kinds[0] && !m_stat[0]) || (kinds[2] && !m_stat[2]);
    nstat = kinds | (m_stat & ~clr);
    @(posedge clk);
    if (reg_we && reg_addr == 4'd0) m_cfg = {4'b0, reg_wdata[3:0]};
    m_stat = nstat;
    if (fload) begin m_fa = f_addr; m_fm = f_mst; m_ft = f_attr; m_fd = f_data; end
    if (rload) begin m_ra = r_addr; m_rs = r_synd; m_rm = r_mst; m_rt = r_attr; m_rd = r_data; end
    #0.5;
    reg_we = 0; f_vld = 0; r_vld = 0;
  endtask

  task automatic write_reg(logic [3:0] a, logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
  endtask

  task automatic flash_err(bit multi, logic [31:0] a, logic [31:0] d);
    f_vld = 1; f_multi = multi; f_addr = a; f_data = d;
    f_mst = 4'(a[3:0] + 1); f_attr = 4'(d[3:0] ^ 4'h5);
  endtask

  task automatic ram_err(bit multi, logic [31:0] a, logic [31:0] d);
    r_vld = 1; r_multi = multi; r_addr = a; r_data = d;
    r_mst = 4'(a[7:4]); r_attr = 4'(d[7:4]); r_synd = 7'(a[6:0] ^ d[6:0]);
  endtask

  initial begin
    m_cfg = 0; m_stat = 0; m_fa = 0; m_fd = 0; m_ra = 0; m_rd = 0;
    m_fm = 0; m_ft = 0; m_rm = 0; m_rt = 0; m_rs = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    check_all("R1 reset");

    // R2: upper configuration bits read zero
    write_reg(4'd0, 8'hFF);
    rd(0, "R2 mask");

    // R5 + R10: all kinds disabled; bus error still asserted
    write_reg(4'd0, 8'h00);
    flash_err(1, 32'hDEAD_0010, 32'h1234_5678);
    ram_err(0, 32'h0000_4440, 32'h0BAD_F00D);
    tick();
    check_all("R5 disabled");

    // R3/R4/R6: enabled flash non-correctable is captured
    write_reg(4'd0, 8'h0F);
    flash_err(1, 32'hA000_0104, 32'hCAFE_0001);
    tick();
    check_all("R6 first flash");

    // R8: second error of the same kind keeps the first capture
    flash_err(1, 32'hB000_0208, 32'hCAFE_0002);
    tick();
    check_all("R8 keep first");

    // R3: writing zero keeps the flag, writing one clears it
    write_reg(4'd1, 8'h00);
    check_all("R3 write zero");
    write_reg(4'd1, 8'h02);
    check_all("R3 clear");

    // R9 + R7: simultaneous flash single-bit and RAM non-correctable
    flash_err(0, 32'hC000_0300, 32'h5555_AAAA);
    ram_err(1, 32'h2000_0ABC, 32'h0F0F_1234);
    tick();
    check_all("R9 simultaneous");

    // R3: clear and new error of the same kind in one cycle, flag stays set
    reg_we = 1; reg_addr = 4'd1; reg_wdata = 8'h01;
    ram_err(1, 32'h2000_0F00, 32'h7777_0000);
    tick();
    check_all("R3 set beats clear");

    write_reg(4'd1, 8'h0F);
    check_all("R4 all cleared");

    // random phase
    for (int n = 0; n < 600; n++) begin
      if (($urandom % 16) == 0)
        write_reg(4'd0, 8'($urandom));
      if (($urandom % 4) == 0) flash_err(1'($urandom), $urandom, $urandom);
      if (($urandom % 4) == 0) ram_err(1'($urandom), $urandom, $urandom);
      if (($urandom % 6) == 0) begin
        reg_we = 1; reg_addr = 4'd1; reg_wdata = 8'($urandom);
      end
      tick();
      rd(1, "R3 random");
      chk({31'b0, irq}, {31'b0, (m_stat != 0)}, "R4 random irq");
      if ((n % 32) == 31) check_all("random");
    end

    finish_up();
  end
endmodule